// File: doc/BRIEF.md
# Stopwatch Digit Collector and Display Scanner

This block links a BCD stopwatch counter to a multiplexed four-digit display. The counter presents one time digit at a time on an 8-bit input bus. It lowers an active-low ready line to offer each digit. The block synchronizes that line and captures the low nibble of the bus on each falling edge. It answers every capture with a one-cycle acknowledge pulse. A rotating slot pointer decides which of the four digit registers receives the value. The counter sends the digits in the fixed order seconds, tens of seconds, hundredths, tenths.

The stored digits are scanned onto an 8-bit display word. The digit value sits in the low nibble and a 2-bit position code sits in the top two bits. The scan advances one position for each cycle in which the scan-tick enable is high.

The block also generates the counter's counting clock. This is a square wave that flips each time a reload timer expires. A start/stop button freezes or releases that timer. After reset the block holds a reset line to the counter high for a few cycles.

Top module: `sw_digit_link`

## Requirements
- R1: The ready line `rtsN` passes through a two-flop synchronizer. Each falling edge captures `digitBus[3:0]` exactly once, three clock edges after the line drops. The upper nibble is discarded, and holding the line low does not cause another capture.
- R2: Successive captures fill the digit registers in the slot order seconds, tens of seconds, hundredths, tenths. After the fourth capture the order restarts at seconds.
- R3: `ackOut` goes high for exactly one cycle per capture. It rises on the same clock edge that stores the digit.
- R4: `dispWord` is {code[1:0], 2'b00, digit[3:0]}. The codes are 2'b01 for tens of seconds, 2'b10 for seconds, 2'b11 for tenths and 2'b00 for hundredths.
- R5: The scan visits tens of seconds, seconds, tenths, hundredths and then repeats. It advances one position on each clock edge where `scanTick` is high and holds when it is low.
- R6: While running, `cntClk` inverts every RELOAD clock cycles (default 2304). It is low after reset.
- R7: Each falling edge of the synchronized `btnN` toggles the run state, which is running out of reset. While stopped, `cntClk` and the timer hold their values.
- R8: During reset and after it, the slot pointer points at seconds and `ackOut` is low. All digits are zero and the scan sits on tens of seconds. `cntReset` is high during reset and for RST_HOLD (default 4) cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| digitBus | input | 8 | Digit from the counter; only bits 3:0 are used |
| rtsN | input | 1 | Active-low ready-to-send strobe from the counter |
| btnN | input | 1 | Active-low start/stop button |
| scanTick | input | 1 | Enable that advances the display scan by one position |
| ackOut | output | 1 | One-cycle acknowledge pulse to the counter |
| cntClk | output | 1 | Counting clock to the counter |
| cntReset | output | 1 | Start-up reset pulse to the counter |
| dispWord | output | 8 | Display word: position code in 7:6, digit in 3:0 |

## Verification
The hardest state to reach is a stopped timer, because the clock output only moves once every 2304 cycles. A missing hold shows up only if the bench waits several reload periods after a button press. The stimulus therefore first measures a full half-period while running. It then stops the timer, waits three reload periods, and confirms that `cntClk` has not moved. Finally it restarts the timer and requires a toggle within one reload period. The slot-to-register mapping and the wrap are reached by random groups of four digits with junk upper nibbles. One of those sends holds the ready line low for many cycles, to prove that only one capture happens.

// File: rtl/sw_link_pkg.sv
package sw_link_pkg;

  // display positions, in scan order
  localparam logic [1:0] POS_TENS   = 2'd0;
  localparam logic [1:0] POS_SECS   = 2'd1;
  localparam logic [1:0] POS_TENTHS = 2'd2;
  localparam logic [1:0] POS_HUNDS  = 2'd3;

  typedef struct packed {
    logic       capture;  // latch the bus into the slot's register
    logic [1:0] slot;     // arrival slot pointer
    logic       run;      // counting-clock timer enabled
    logic [1:0] scanPos;  // display position being shown
  } ctrl_s;

  // arrival slot -> display position
  function automatic logic [1:0] slotToPos(input logic [1:0] slot);
    case (slot)
      2'd0:    slotToPos = POS_SECS;
      2'd1:    slotToPos = POS_TENS;
      2'd2:    slotToPos = POS_HUNDS;
      default: slotToPos = POS_TENTHS;
    endcase
  endfunction

  // display position -> code in the top two bits of the display word
  function automatic logic [1:0] posCode(input logic [1:0] pos);
    case (pos)
      POS_TENS:   posCode = 2'b01;
      POS_SECS:   posCode = 2'b10;
      POS_TENTHS: posCode = 2'b11;
      default:    posCode = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/sw_sync_fall.sv
module sw_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] pipeQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ <= '1;
      prevQ <= 1'b1;
    end else begin
      pipeQ <= {pipeQ[STAGES-2:0], din};
      prevQ <= pipeQ[STAGES-1];
    end
  end

  assign fall = prevQ & ~pipeQ[STAGES-1];

  a_r1_single_fall: assert property (@(posedge clk) disable iff (!rstN)
    fall |=> !fall);
endmodule

// File: rtl/sw_link_ctrl.sv
module sw_link_ctrl
  import sw_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 4
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  rtsN,
  input  logic  btnN,
  input  logic  scanTick,
  output ctrl_s ctl,
  output logic  ackOut,
  output logic  cntReset
);
  localparam int RCW = $clog2(RST_HOLD + 1);

  logic           rtsFall, btnFall;
  logic [1:0]     slotQ, scanQ;
  logic           runQ, ackQ;
  logic [RCW-1:0] rstCntQ;

  sw_sync_fall #(.STAGES(SYNC_STAGES)) uRtsSync (
    .clk(clk), .rstN(rstN), .din(rtsN), .fall(rtsFall));
  sw_sync_fall #(.STAGES(SYNC_STAGES)) uBtnSync (
    .clk(clk), .rstN(rstN), .din(btnN), .fall(btnFall));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ   <= 2'd0;
      scanQ   <= POS_TENS;
      runQ    <= 1'b1;
      ackQ    <= 1'b0;
      rstCntQ <= RCW'(RST_HOLD);
    end else begin
      ackQ <= rtsFall;
      if (rtsFall) slotQ <= slotQ + 2'd1;
      if (btnFall) runQ <= ~runQ;
      if (scanTick) scanQ <= scanQ + 2'd1;
      if (rstCntQ != '0) rstCntQ <= rstCntQ - RCW'(1);
    end
  end

  always_comb begin
    ctl.capture = rtsFall;
    ctl.slot    = slotQ;
    ctl.run     = runQ;
    ctl.scanPos = scanQ;
  end

  assign ackOut   = ackQ;
  assign cntReset = (rstCntQ != '0);

  a_r3_ack_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);
  a_r3_ack_follows_capture: assert property (@(posedge clk) disable iff (!rstN)
    rtsFall |=> ackOut);
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rtsFall && slotQ == 2'd3) |=> slotQ == 2'd0);
  a_r5_scan_hold: assert property (@(posedge clk) disable iff (!rstN)
    !scanTick |=> $stable(scanQ));
  a_r7_run_toggle: assert property (@(posedge clk) disable iff (!rstN)
    btnFall |=> runQ != $past(runQ));
endmodule

// File: rtl/sw_link_datapath.sv
module sw_link_datapath
  import sw_link_pkg::*;
#(
  parameter int RELOAD = 2304
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_s      ctl,
  input  logic [7:0] digitBus,
  output logic [7:0] dispWord,
  output logic       cntClk
);
  localparam int TW = $clog2(RELOAD);

  logic [3:0]    digitQ [4];
  logic [TW-1:0] timerQ;
  logic          clkQ;
  logic [1:0]    capPos;

  assign capPos = slotToPos(ctl.slot);

  for (genvar g = 0; g < 4; g++) begin : gDigit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        digitQ[g] <= 4'd0;
      else if (ctl.capture && capPos == 2'(g))
        digitQ[g] <= digitBus[3:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
      clkQ   <= 1'b0;
    end else if (ctl.run) begin
      if (timerQ == TW'(RELOAD - 1)) begin
        timerQ <= '0;
        clkQ   <= ~clkQ;
      end else begin
        timerQ <= timerQ + TW'(1);
      end
    end
  end

  assign cntClk   = clkQ;
  assign dispWord = {posCode(ctl.scanPos), 2'b00, digitQ[ctl.scanPos]};

  a_r7_clk_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> $stable(cntClk));
  a_r7_timer_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> $stable(timerQ));
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    timerQ < TW'(RELOAD));
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    dispWord[5:4] == 2'b00);
endmodule

// File: rtl/sw_digit_link.sv
module sw_digit_link
  import sw_link_pkg::*;
#(
  parameter int RELOAD      = 2304,
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] digitBus,
  input  logic       rtsN,
  input  logic       btnN,
  input  logic       scanTick,
  output logic       ackOut,
  output logic       cntClk,
  output logic       cntReset,
  output logic [7:0] dispWord
);
  ctrl_s ctl;

  sw_link_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD)) uCtrl (
    .clk(clk), .rstN(rstN), .rtsN(rtsN), .btnN(btnN), .scanTick(scanTick),
    .ctl(ctl), .ackOut(ackOut), .cntReset(cntReset));

  sw_link_datapath #(.RELOAD(RELOAD)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .digitBus(digitBus),
    .dispWord(dispWord), .cntClk(cntClk));
endmodule

// File: tb/sw_digit_link_test.sv
`timescale 1ns/1ps
module sw_digit_link_test;
  localparam int RELOAD = 2304;
  localparam int HOLD   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] digitBus = 8'h00;
  logic rtsN = 1'b1, btnN = 1'b1, scanTick = 1'b0;
  logic ackOut, cntClk, cntReset;
  logic [7:0] dispWord;

  int nVec = 0, nBad = 0;
  int expDig [4];
  int expSlot = 0, expPos = 0;

  always #10 clk = ~clk;

  sw_digit_link #(.RELOAD(RELOAD), .SYNC_STAGES(2), .RST_HOLD(HOLD)) uut (
    .clk(clk), .rstN(rstN), .digitBus(digitBus), .rtsN(rtsN), .btnN(btnN),
    .scanTick(scanTick), .ackOut(ackOut), .cntClk(cntClk),
    .cntReset(cntReset), .dispWord(dispWord));

  function automatic int slotPos(int s);
    case (s) 0: return 1; 1: return 0; 2: return 3; default: return 2; endcase
  endfunction

  function automatic logic [1:0] codeOf(int p);
    case (p) 0: return 2'b01; 1: return 2'b10; 2: return 2'b11; default: return 2'b00; endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  // R1, R3: send one digit and check acknowledge timing
  task automatic sendDigit(input int d, input int extraLow);
    logic [3:0] junk = 4'($urandom_range(15));
    @(negedge clk);
    digitBus = {junk, 4'(d)};
    rtsN = 1'b0;
    @(negedge clk); check(ackOut == 1'b0, "R3 early", ackOut, 0);
    @(negedge clk); check(ackOut == 1'b0, "R3 early", ackOut, 0);
    @(negedge clk); check(ackOut == 1'b1, "R3 ack", ackOut, 1);
    @(negedge clk); check(ackOut == 1'b0, "R3 width", ackOut, 0);
    for (int i = 0; i < extraLow; i++) begin
      @(negedge clk); check(ackOut == 1'b0, "R1 held low", ackOut, 0);
    end
    rtsN = 1'b1;
    digitBus = 8'hFF;
    repeat (4) @(negedge clk);
    expDig[slotPos(expSlot)] = d;
    expSlot = (expSlot + 1) % 4;
  endtask

  // R4, R5: walk the scan and compare every word
  task automatic scanCheck(input int steps);
    for (int k = 0; k < steps; k++) begin
      check(dispWord == {codeOf(expPos), 2'b00, 4'(expDig[expPos])},
            "R2/R4/R5 display", dispWord, {codeOf(expPos), 2'b00, 4'(expDig[expPos])});
      scanTick = 1'b1;
      @(negedge clk);
      scanTick = 1'b0;
      expPos = (expPos + 1) % 4;
    end
  endtask

  task automatic waitToggle(output int n);
    logic start = cntClk;
    n = 0;
    while (cntClk == start && n < 4 * RELOAD) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pressBtn;
    @(negedge clk); btnN = 1'b0;
    repeat (4) @(negedge clk);
    btnN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int c1, c2;
    logic lvl;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) expDig[i] = 0;

    // R8 reset state
    repeat (3) @(negedge clk);
    check(cntReset == 1'b1, "R8 cntReset in reset", cntReset, 1);
    check(ackOut == 1'b0, "R8 ack in reset", ackOut, 0);
    check(dispWord == 8'h40, "R8 display in reset", dispWord, 8'h40);
    check(cntClk == 1'b0, "R6 clk in reset", cntClk, 0);
    rstN = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    check(cntReset == 1'b1, "R8 cntReset hold", cntReset, 1);
    @(negedge clk);
    check(cntReset == 1'b0, "R8 cntReset release", cntReset, 0);

    // R5 scan holds without tick
    repeat (3) @(negedge clk);
    check(dispWord == 8'h40, "R5 hold", dispWord, 8'h40);

    // R1, R2: directed group, one send held low for long
    sendDigit(7, 0);
    sendDigit(3, 12);
    sendDigit(9, 0);
    sendDigit(5, 0);
    scanCheck(8);
    // R2 wrap: partial group overwrites seconds and tens only
    sendDigit(1, 0);
    sendDigit(8, 0);
    scanCheck(4);
    sendDigit(0, 0);
    sendDigit(9, 0);

    // random groups
    for (int g = 0; g < 6; g++) begin
      for (int s = 0; s < 4; s++) sendDigit($urandom_range(9), $urandom_range(3));
      scanCheck(4 + $urandom_range(3));
    end

    // R6 clock period
    waitToggle(c1);
    waitToggle(c2);
    check(c2 == RELOAD, "R6 half period", c2, RELOAD);
    waitToggle(c2);
    check(c2 == RELOAD, "R6 half period", c2, RELOAD);

    // R7 stop and hold
    pressBtn();
    lvl = cntClk;
    repeat (3 * RELOAD) @(negedge clk);
    check(cntClk == lvl, "R7 stopped hold", cntClk, lvl);
    // R7 resume
    pressBtn();
    waitToggle(c1);
    check(c1 > 0 && c1 <= RELOAD, "R7 resume", c1, RELOAD);
    waitToggle(c2);
    check(c2 == RELOAD, "R7 period after resume", c2, RELOAD);

    // display still intact after clock activity
    scanCheck(4);
    summary();
  end
endmodule